// File: doc/BRIEF.md
# Dual Address Breakpoint Comparator

This block watches a stream of effective addresses, at most one per clock, and tests each against two programmable breakpoint slots. Each slot holds a bound address, an enable bit and a class bit, which names the kind of address the slot watches: instruction fetch or data access. Each slot has its own selectable relation between the incoming address and its bound. A control register chooses how the two slot results are combined. In separate mode each slot drives its own watchpoint output. In fused mode the second watchpoint fires only when both slots match the same address, which forms an inside-range or outside-range window.

Every match raises a breakpoint request at once; no occurrences are counted. The request carries the matching address and its class. An instruction is presented as one instruction-class address followed by any number of data-class addresses. The request keeps the first match recorded for the current instruction, so an instruction breakpoint takes priority over a data breakpoint of the same instruction. Software programs the slots through a simple write port. The control register can only be changed while both slots are disabled.

Top module: `addr_bkpt_pair`

## Requirements
- R1: A slot's relation code selects how the address `ea` is tested against its bound `b`, as an unsigned comparison over the full width: 0 means `ea == b`, 1 means `ea < b`, 2 means `ea > b`, and 3 means `ea <= b`.
- R2: A slot can match only when its enable bit is 1 and its class bit equals `ea_cls` (0 = instruction, 1 = data).
- R3: In separate mode (control bit 0 = 0), `wp1` in the cycle after a valid address equals slot 1's match and `wp2` equals slot 2's match.
- R4: In fused mode (control bit 0 = 1), `wp2` is high only when both slots match the same valid address, and `wp1` stays low.
- R5: Slot 1 set to "less than" and slot 2 set to "greater than", in separate mode, request a breakpoint for every address outside the closed range [bound1, bound2]. Slot 1 set to "greater than" and slot 2 set to "less or equal", in fused mode, raise `wp2` for bound1 < ea <= bound2.
- R6: The watchpoints are registered. Each one is high for exactly the one full cycle that follows a matching valid address, and both are low after a cycle in which `ea_vld` is 0.
- R7: A match raises `brk_req` in the next cycle with no counting. `brk_addr` then holds the matching address and `brk_cls` holds its class. Both read 0 while no request is held.
- R8: A held request stays unchanged through idle cycles and data-class addresses. It is reloaded on the next valid instruction-class address: it is set from that address if the address matches, and cleared otherwise.
- R9: While a request is held, a later data-class match does not replace it. An instruction-class request therefore wins over the data matches of the same instruction.
- R10: A write to the control register is ignored while either slot is enabled.
- R11: `wr_sel` 0 writes slot 1 and `wr_sel` 1 writes slot 2, with `wr_data` laid out as {enable, class, bound}. `wr_sel` 2 writes the control register from `wr_data[4:0]` as {relation 2, relation 1, fused mode}. `wr_sel` 3 is ignored.
- R12: After reset both slots are disabled, the control register is 0 (separate mode, both relations equal), and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: slot 1, slot 2, control |
| wr_data | input | ADDR_W+2 | Write data: {enable, class, bound} or control bits |
| ea_vld | input | 1 | Effective address valid |
| ea_cls | input | 1 | Address class: 0 instruction, 1 data |
| ea | input | ADDR_W | Effective address |
| wp1 | output | 1 | Watchpoint 1 |
| wp2 | output | 1 | Watchpoint 2 (fused result in fused mode) |
| brk_req | output | 1 | Breakpoint request held for the current instruction |
| brk_cls | output | 1 | Class of the recorded match |
| brk_addr | output | ADDR_W | Address of the recorded match |

## Verification
The bench builds the block with ADDR_W = 4, so each address space has only sixteen values. This makes it possible to sweep every bound for every relation against every address, in both separate and fused mode, with the expected watchpoints and request computed arithmetically. The small width also makes the equality edges, zero and the all-ones address fall inside every sweep. The window shapes, the instruction-then-data request sequence and the control-register lock are driven as short directed sequences.

// File: rtl/abp_pkg.sv
package abp_pkg;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_LE = 2'd3
    } rel_e;

    // control word, least significant field first in wr_data: fused, rel1, rel2
    typedef struct packed {
        rel_e rel2;
        rel_e rel1;
        logic fused;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] SEL_SLOT1 = 2'd0;
    localparam logic [1:0] SEL_SLOT2 = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

endpackage

// File: rtl/abp_regfile.sv
module abp_regfile
    import abp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [ADDR_W+1:0]      wr_data,
    output logic [1:0][ADDR_W-1:0] slot_bound,
    output logic [1:0]             slot_en,
    output logic [1:0]             slot_cls,
    output ctrl_t                  ctrl
);
    localparam int WD_W = ADDR_W + 2;

    typedef struct packed {
        ctrl_t                  ctrl;
        logic [1:0]             en;
        logic [1:0]             cls;
        logic [1:0][ADDR_W-1:0] bound;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_SLOT1: begin
                    regs_d.en[0]    = wr_data[WD_W-1];
                    regs_d.cls[0]   = wr_data[WD_W-2];
                    regs_d.bound[0] = wr_data[ADDR_W-1:0];
                end
                SEL_SLOT2: begin
                    regs_d.en[1]    = wr_data[WD_W-1];
                    regs_d.cls[1]   = wr_data[WD_W-2];
                    regs_d.bound[1] = wr_data[ADDR_W-1:0];
                end
                SEL_CTRL: begin
                    // mode and relations are frozen while any slot is armed
                    if (regs_q.en == 2'b00) begin
                        regs_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign slot_bound = regs_q.bound;
    assign slot_en    = regs_q.en;
    assign slot_cls   = regs_q.cls;
    assign ctrl       = regs_q.ctrl;

    // R10: control stays put when written while armed
    p_ctrl_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL && regs_q.en != 2'b00) |=> $stable(regs_q.ctrl));

    // R11: unused select writes nothing
    p_sel3_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> $stable(regs_q));

endmodule

// File: rtl/abp_compare.sv
module abp_compare
    import abp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] ea,
    input  logic              ea_cls,
    input  logic [ADDR_W-1:0] bound,
    input  logic              en,
    input  logic              cls,
    input  rel_e              rel,
    output logic              hit
);
    logic rel_ok;

    always_comb begin
        case (rel)
            REL_EQ:  rel_ok = (ea == bound);
            REL_LT:  rel_ok = (ea <  bound);
            REL_GT:  rel_ok = (ea >  bound);
            default: rel_ok = (ea <= bound);
        endcase
        hit = en && (cls == ea_cls) && rel_ok;
    end

endmodule

// File: rtl/abp_merge.sv
module abp_merge #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ea_vld,
    input  logic              ea_cls,
    input  logic [ADDR_W-1:0] ea,
    input  logic [1:0]        hit,
    input  logic              fused,
    output logic              wp1,
    output logic              wp2,
    output logic              brk_req,
    output logic              brk_cls,
    output logic [ADDR_W-1:0] brk_addr
);
    typedef struct packed {
        logic              wp1;
        logic              wp2;
        logic              req;
        logic              cls;
        logic [ADDR_W-1:0] addr;
    } mrg_t;

    mrg_t mrg_d, mrg_q;
    logic any_hit;

    always_comb begin
        mrg_d     = mrg_q;
        mrg_d.wp1 = ea_vld && hit[0] && !fused;
        mrg_d.wp2 = ea_vld && (fused ? (hit[0] && hit[1]) : hit[1]);
        any_hit   = mrg_d.wp1 || mrg_d.wp2;
        if (ea_vld) begin
            if (!ea_cls) begin
                // a new instruction starts: reload the request
                mrg_d.req  = any_hit;
                mrg_d.cls  = 1'b0;
                mrg_d.addr = any_hit ? ea : '0;
            end else if (!mrg_q.req && any_hit) begin
                mrg_d.req  = 1'b1;
                mrg_d.cls  = 1'b1;
                mrg_d.addr = ea;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mrg_q <= '0;
        end else begin
            mrg_q <= mrg_d;
        end
    end

    assign wp1      = mrg_q.wp1;
    assign wp2      = mrg_q.wp2;
    assign brk_req  = mrg_q.req;
    assign brk_cls  = mrg_q.cls;
    assign brk_addr = mrg_q.addr;

    // R4: first watchpoint silent in fused mode
    p_fused_wp1_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fused |=> !mrg_q.wp1);

    // R4: second watchpoint needs both slots
    p_fused_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fused && !(hit[0] && hit[1])) |=> !mrg_q.wp2);

    // R6: no watchpoint after an idle cycle
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ea_vld |=> (!mrg_q.wp1 && !mrg_q.wp2));

    // R8: idle cycles keep the request
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ea_vld |=> ($stable(mrg_q.req) && $stable(mrg_q.addr) && $stable(mrg_q.cls)));

    // R9: an instruction request survives data matches
    p_instr_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mrg_q.req && !mrg_q.cls && ea_vld && ea_cls)
        |=> (mrg_q.req && !mrg_q.cls && $stable(mrg_q.addr)));

    // R7: address reads zero without a request
    p_addr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mrg_q.req |-> (mrg_q.addr == '0 && !mrg_q.cls));

endmodule

// File: rtl/addr_bkpt_pair.sv
module addr_bkpt_pair
    import abp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W+1:0] wr_data,
    input  logic              ea_vld,
    input  logic              ea_cls,
    input  logic [ADDR_W-1:0] ea,
    output logic              wp1,
    output logic              wp2,
    output logic              brk_req,
    output logic              brk_cls,
    output logic [ADDR_W-1:0] brk_addr
);
    localparam int NSLOT = 2;

    logic [NSLOT-1:0][ADDR_W-1:0] slot_bound;
    logic [NSLOT-1:0]             slot_en;
    logic [NSLOT-1:0]             slot_cls;
    logic [NSLOT-1:0]             hit;
    ctrl_t                        ctrl;
    rel_e                         slot_rel [NSLOT];

    assign slot_rel[0] = ctrl.rel1;
    assign slot_rel[1] = ctrl.rel2;

    abp_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .slot_bound (slot_bound),
        .slot_en    (slot_en),
        .slot_cls   (slot_cls),
        .ctrl       (ctrl)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        abp_compare #(.ADDR_W(ADDR_W)) u_cmp (
            .ea     (ea),
            .ea_cls (ea_cls),
            .bound  (slot_bound[g]),
            .en     (slot_en[g]),
            .cls    (slot_cls[g]),
            .rel    (slot_rel[g]),
            .hit    (hit[g])
        );

        // R2: a disabled slot never reports a hit
        p_disabled_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_en[g] |-> !hit[g]);
    end

    abp_merge #(.ADDR_W(ADDR_W)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ea_vld   (ea_vld),
        .ea_cls   (ea_cls),
        .ea       (ea),
        .hit      (hit),
        .fused    (ctrl.fused),
        .wp1      (wp1),
        .wp2      (wp2),
        .brk_req  (brk_req),
        .brk_cls  (brk_cls),
        .brk_addr (brk_addr)
    );

endmodule

// File: tb/addr_bkpt_pair_bench.sv
module addr_bkpt_pair_bench;
    localparam int AW = 4;
    localparam int NA = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [AW+1:0] wr_data = '0;
    logic          ea_vld = 1'b0;
    logic          ea_cls = 1'b0;
    logic [AW-1:0] ea = '0;
    logic          wp1, wp2, brk_req, brk_cls;
    logic [AW-1:0] brk_addr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // shadow state built from the requirements
    logic       s_en [2];
    logic       s_cls [2];
    int         s_bound [2];
    int         s_rel [2];
    logic       s_fused;
    logic       x_req, x_cls;
    int         x_addr;

    always #5 clk = ~clk;

    addr_bkpt_pair #(.ADDR_W(AW)) u_addr_bkpt_pair (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ea_vld(ea_vld), .ea_cls(ea_cls), .ea(ea),
        .wp1(wp1), .wp2(wp2), .brk_req(brk_req), .brk_cls(brk_cls), .brk_addr(brk_addr)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic rel_hit(input int rel, input int a, input int b);
        case (rel)
            0: return a == b;
            1: return a < b;
            2: return a > b;
            default: return a <= b;
        endcase
    endfunction

    // R11: sel 0/1 = slot {en, cls, bound}, sel 2 = control {rel2, rel1, fused}
    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel[1:0]; wr_data = data[AW+1:0];
        if (sel < 2) begin
            s_en[sel]    = data[AW+1];
            s_cls[sel]   = data[AW];
            s_bound[sel] = data & (NA - 1);
        end else if (sel == 2 && !s_en[0] && !s_en[1]) begin
            s_fused  = data[0];
            s_rel[0] = (data >> 1) & 3;
            s_rel[1] = (data >> 3) & 3;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int slot_word(input int en, input int cls, input int b);
        return (en << (AW + 1)) | (cls << AW) | b;
    endfunction

    task automatic prog(input int fused, input int r1, input int r2,
                        input int b1, input int b2, input int c1, input int c2);
        wr(0, slot_word(0, c1, b1));
        wr(1, slot_word(0, c2, b2));
        wr(2, (r2 << 3) | (r1 << 1) | fused);
        wr(0, slot_word(1, c1, b1));
        wr(1, slot_word(1, c2, b2));
    endtask

    task automatic step(input logic v, input logic c, input int a);
        logic m1, m2, e1, e2, any;
        @(negedge clk);
        ea_vld = v; ea_cls = c; ea = a[AW-1:0];
        m1 = s_en[0] && (s_cls[0] == c) && rel_hit(s_rel[0], a, s_bound[0]);
        m2 = s_en[1] && (s_cls[1] == c) && rel_hit(s_rel[1], a, s_bound[1]);
        e1 = v && m1 && !s_fused;
        e2 = v && (s_fused ? (m1 && m2) : m2);
        any = e1 || e2;
        if (v) begin
            if (!c) begin
                x_req = any; x_cls = 1'b0; x_addr = any ? a : 0;
            end else if (!x_req && any) begin
                x_req = 1'b1; x_cls = 1'b1; x_addr = a;
            end
        end
        @(negedge clk);
        chk(wp1, e1, s_fused ? "R4 wp1" : "R1/R3 wp1");
        chk(wp2, e2, s_fused ? "R4 wp2" : "R1/R3 wp2");
        chk(brk_req, x_req, "R7 brk_req");
        chk(brk_cls, x_cls, "R9 brk_cls");
        chk(brk_addr, x_addr, "R7 brk_addr");
        ea_vld = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            s_en[i] = 0; s_cls[i] = 0; s_bound[i] = 0; s_rel[i] = 0;
        end
        s_fused = 0; x_req = 0; x_cls = 0; x_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        chk(wp1, 0, "R12 wp1");
        chk(wp2, 0, "R12 wp2");
        chk(brk_req, 0, "R12 brk_req");
        chk(brk_addr, 0, "R12 brk_addr");
        step(1, 0, 0);  // slots disabled after reset: bound 0 equal must not hit
        chk(brk_req, 0, "R12 disabled after reset");

        // separate-mode sweep: every relation, bound and address
        for (int r = 0; r < 4; r++)
            for (int b = 0; b < NA; b++) begin
                prog(0, r, 3 - r, b, NA - 1 - b, 0, 0);
                for (int e = 0; e < NA; e++) step(1, 0, e);
            end

        // fused-mode sweep
        for (int r = 0; r < 4; r++)
            for (int b = 0; b < NA; b++) begin
                prog(1, r, (r + 1) % 4, b, NA - 1 - b, 0, 0);
                for (int e = 0; e < NA; e++) step(1, 0, e);
            end

        // R5: outside range [5,10]
        prog(0, 1, 2, 5, 10, 0, 0);
        for (int e = 0; e < NA; e++) begin
            step(1, 0, e);
            chk(brk_req, (e < 5 || e > 10), "R5 outside window");
        end
        // R5: inside window (5,10]
        prog(1, 2, 3, 5, 10, 0, 0);
        for (int e = 0; e < NA; e++) begin
            step(1, 0, e);
            chk(wp2, (e > 5 && e <= 10), "R5 inside window");
        end

        // R2: class filtering and enable gating
        prog(0, 0, 0, 7, 7, 1, 1);
        step(1, 0, 7);
        chk(wp1 | wp2, 0, "R2 class mismatch");
        step(1, 1, 7);
        chk(wp1 & wp2, 1, "R2 class match");
        wr(0, slot_word(0, 1, 7));
        step(1, 1, 7);
        chk(wp1, 0, "R2 disabled slot");
        chk(wp2, 1, "R11 slot2 still armed");

        // R6: single-cycle pulse, quiet after idle
        prog(0, 0, 0, 7, 7, 0, 0);
        step(1, 0, 7);
        chk(wp1, 1, "R6 pulse high");
        @(negedge clk);
        chk(wp1, 0, "R6 pulse ends");
        step(0, 0, 7);
        chk(wp1 | wp2, 0, "R6 idle quiet");

        // R8, R9: request sequence across instructions
        prog(0, 0, 0, 3, 9, 0, 1);
        step(1, 0, 3);
        chk(brk_req, 1, "R7 instr match");
        step(1, 1, 9);
        chk(brk_cls, 0, "R9 instr wins");
        chk(brk_addr, 3, "R9 instr addr kept");
        step(0, 0, 0);
        chk(brk_req, 1, "R8 hold idle");
        step(1, 0, 4);
        chk(brk_req, 0, "R8 cleared by next instr");
        step(1, 1, 9);
        chk(brk_cls, 1, "R7 data request");
        chk(brk_addr, 9, "R7 data addr");
        step(1, 0, 3);
        chk(brk_cls, 0, "R8 reload instr");

        // R10: control locked while armed
        prog(0, 0, 0, 2, 2, 0, 0);
        wr(2, 1);
        step(1, 0, 2);
        chk(wp1, 1, "R10 write ignored");
        wr(0, slot_word(0, 0, 2));
        wr(1, slot_word(0, 0, 2));
        wr(2, 1);
        wr(0, slot_word(1, 0, 2));
        wr(1, slot_word(1, 0, 2));
        step(1, 0, 2);
        chk(wp1, 0, "R10 fused after unlock");
        chk(wp2, 1, "R10 fused wp2");

        // R11: select 3 writes nothing
        wr(3, slot_word(0, 1, 5));
        step(1, 0, 2);
        chk(wp2, 1, "R11 sel3 ignored");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule